// File: doc/BRIEF.md
# Five-Stage Pipelined Integer Core

This block is an in-order integer core with five stages: fetch, decode with register read, execute, memory and write-back. It runs a small load/store subset: register add and subtract, OR with a 16-bit immediate, word load, word store, branch-if-equal and an absolute jump. Instruction words and data words sit in two separate internal word-addressed arrays, so a fetch and a data access never compete for one port. Once the pipeline is full, one instruction retires every cycle.

The register file writes early in the cycle and reads late. An instruction in decode therefore sees the value that write-back commits in the same cycle. ALU results are forwarded from the two later pipeline registers. A load that feeds the next instruction costs one bubble. A taken branch is resolved in execute and discards the two younger instructions. A jump is resolved in decode and discards one. Software loads the program through a debug write port into instruction storage while reset is held. A debug read port shows any architectural register.

Top module: `mini_pipe_core`

## Requirements
- R1: While `rst_ni` is low, the PC is 0, every pipeline slot is a bubble and every register reads 0 through the debug port.
- R2: R-type with opcode 000000 and function 100000 adds, and with function 100010 subtracts (rd = rs - rt, two's complement). Opcode 001101 ORs rs with the zero-extended 16-bit immediate into rt.
- R3: Opcode 100011 loads rt from the data word at rs + sign-extended offset. Opcode 101011 stores rt there. Byte addresses are word-aligned, and word index = address[DAW+1:2].
- R4: An instruction that reads a register written by one of the two instructions just ahead of it receives the new value without stalling.
- R5: A register written back in the same cycle that a younger instruction reads it in decode delivers the new value.
- R6: An instruction that uses the target of the load immediately ahead of it stalls one cycle. PC and the decode slot hold, a bubble enters execute, and the result is correct.
- R7: Branch-if-equal (opcode 000100) resolves in execute. If it is taken, the PC becomes PC+4 + (sign-extended offset << 2) and the two younger instructions have no effect. If it is not taken, execution falls through.
- R8: Jump (opcode 000010) loads the PC with {PC+4[31:28], target26, 2'b00} and discards the one instruction fetched behind it.
- R9: Register 0 always reads 0, and writes to it are ignored.
- R10: Any opcode or R-type function outside the subset acts as a no-op: no register or data write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| imem_we_i | input | 1 | Debug write strobe into instruction storage |
| imem_addr_i | input | $clog2(IMEM_WORDS) | Debug instruction word index |
| imem_wdata_i | input | 32 | Debug instruction word |
| dbg_raddr_i | input | 5 | Debug register index |
| dbg_rdata_o | output | 32 | Debug register value |

## Verification
The assertions assume that instruction storage is written only while reset holds the core. They also assume that every load and store address is word-aligned and falls inside the data array. The stimulus preloads the whole program under reset and releases reset only after that. Every memory offset in the program is a multiple of four within the array. The program is ordered to hit each hazard path on purpose: an immediate use after an ALU op, a use three slots after the write, a load followed by its user, and flushes under branches and jumps.

// File: rtl/mini_pipe_pkg.sv
package mini_pipe_pkg;
  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_ORI   = 6'b001101;
  localparam logic [5:0] OP_LW    = 6'b100011;
  localparam logic [5:0] OP_SW    = 6'b101011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_J     = 6'b000010;
  localparam logic [5:0] FN_ADD   = 6'b100000;
  localparam logic [5:0] FN_SUB   = 6'b100010;

  typedef enum logic [1:0] {
    ALU_ADD = 2'b00,
    ALU_SUB = 2'b01,
    ALU_OR  = 2'b10
  } alu_op_e;

  typedef struct packed {
    logic    reg_dst;
    logic    alu_src;
    logic    mem_to_reg;
    logic    reg_write;
    logic    mem_write;
    logic    branch;
    logic    jump;
    logic    ext_sign;
    alu_op_e alu_op;
    logic    use_rs;
    logic    use_rt;
  } ctrl_t;
endpackage

// File: rtl/mini_pipe_decoder.sv
module mini_pipe_decoder
  import mini_pipe_pkg::*;
(
  input  logic [5:0] op_i,
  input  logic [5:0] funct_i,
  output ctrl_t      ctrl_o
);
  logic is_r, is_add, is_sub, is_ori, is_lw, is_sw, is_beq, is_j;

  always_comb begin
    is_r   = (op_i == OP_RTYPE);
    is_add = is_r & (funct_i == FN_ADD);
    is_sub = is_r & (funct_i == FN_SUB);
    is_ori = (op_i == OP_ORI);
    is_lw  = (op_i == OP_LW);
    is_sw  = (op_i == OP_SW);
    is_beq = (op_i == OP_BEQ);
    is_j   = (op_i == OP_J);

    ctrl_o.reg_dst    = is_add | is_sub;
    ctrl_o.alu_src    = is_ori | is_lw | is_sw;
    ctrl_o.mem_to_reg = is_lw;
    ctrl_o.reg_write  = is_add | is_sub | is_ori | is_lw;
    ctrl_o.mem_write  = is_sw;
    ctrl_o.branch     = is_beq;
    ctrl_o.jump       = is_j;
    ctrl_o.ext_sign   = is_lw | is_sw;
    ctrl_o.alu_op     = alu_op_e'({is_ori, is_sub | is_beq});
    ctrl_o.use_rs     = is_add | is_sub | is_ori | is_lw | is_sw | is_beq;
    ctrl_o.use_rt     = is_add | is_sub | is_sw | is_beq;
  end
endmodule

// File: rtl/mini_pipe_regfile.sv
module mini_pipe_regfile #(
  parameter int unsigned NREG  = 32,
  parameter int unsigned XLEN  = 32,
  localparam int unsigned AW   = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [AW-1:0]   waddr_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic [AW-1:0]   ra_a_i,
  output logic [XLEN-1:0] rd_a_o,
  input  logic [AW-1:0]   ra_b_i,
  output logic [XLEN-1:0] rd_b_o,
  input  logic [AW-1:0]   ra_dbg_i,
  output logic [XLEN-1:0] rd_dbg_o
);
  logic [XLEN-1:0] regs_q [NREG];
  logic            wr_ok;

  assign wr_ok = we_i & (waddr_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (wr_ok) begin
      regs_q[waddr_i] <= wdata_i;
    end
  end

  // write-then-read within the cycle
  function automatic logic [XLEN-1:0] rd_port(input logic [AW-1:0] a);
    if (a == '0)                 return '0;
    else if (wr_ok && a == waddr_i) return wdata_i;
    else                         return regs_q[a];
  endfunction

  assign rd_a_o   = rd_port(ra_a_i);
  assign rd_b_o   = rd_port(ra_b_i);
  assign rd_dbg_o = (ra_dbg_i == '0) ? '0 : regs_q[ra_dbg_i];
endmodule

// File: rtl/mini_pipe_hazard.sv
module mini_pipe_hazard (
  input  logic       ifid_valid_i,
  input  logic [4:0] id_rs_i,
  input  logic [4:0] id_rt_i,
  input  logic       id_use_rs_i,
  input  logic       id_use_rt_i,
  input  logic       idex_load_i,
  input  logic [4:0] idex_dest_i,
  input  logic [4:0] idex_rs_i,
  input  logic [4:0] idex_rt_i,
  input  logic       exmem_we_i,
  input  logic [4:0] exmem_dest_i,
  input  logic       memwb_we_i,
  input  logic [4:0] memwb_dest_i,
  output logic       stall_o,
  output logic [1:0] fwd_a_o,
  output logic [1:0] fwd_b_o
);
  function automatic logic [1:0] pick(input logic [4:0] src);
    if (exmem_we_i && exmem_dest_i != 5'd0 && exmem_dest_i == src)      return 2'd1;
    else if (memwb_we_i && memwb_dest_i != 5'd0 && memwb_dest_i == src) return 2'd2;
    else                                                                 return 2'd0;
  endfunction

  assign fwd_a_o = pick(idex_rs_i);
  assign fwd_b_o = pick(idex_rt_i);

  assign stall_o = ifid_valid_i & idex_load_i & (idex_dest_i != 5'd0) &
                   ((id_use_rs_i & (id_rs_i == idex_dest_i)) |
                    (id_use_rt_i & (id_rt_i == idex_dest_i)));
endmodule

// File: rtl/mini_pipe_core.sv
module mini_pipe_core
  import mini_pipe_pkg::*;
#(
  parameter int unsigned IMEM_WORDS = 64,
  parameter int unsigned DMEM_WORDS = 64
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          imem_we_i,
  input  logic [$clog2(IMEM_WORDS)-1:0] imem_addr_i,
  input  logic [31:0]                   imem_wdata_i,
  input  logic [4:0]                    dbg_raddr_i,
  output logic [31:0]                   dbg_rdata_o
);
  localparam int unsigned IAW = $clog2(IMEM_WORDS);
  localparam int unsigned DAW = $clog2(DMEM_WORDS);

  // fetch
  logic [31:0] imem_q [IMEM_WORDS];
  logic [31:0] pc_q, if_pc4, if_instr;

  // IF/ID
  logic        ifid_valid;
  logic [31:0] ifid_instr, ifid_pc4;

  // decode
  ctrl_t       id_ctrl_raw, id_ctrl;
  logic [4:0]  id_rs, id_rt, id_rd;
  logic [31:0] id_a, id_b, id_imm, id_br_target, id_jmp_target;
  logic        jump_go;

  // ID/EX
  ctrl_t       idex_ctrl;
  logic [4:0]  idex_rs, idex_rt, idex_dest;
  logic [31:0] idex_a, idex_b, idex_imm, idex_br_target;

  // execute
  logic [1:0]  fwd_a, fwd_b;
  logic [31:0] ex_a, ex_b_reg, ex_b, ex_res;
  logic        br_taken, stall;

  // EX/MEM
  logic        exmem_we, exmem_load, exmem_store;
  logic [31:0] exmem_res, exmem_sdata;
  logic [4:0]  exmem_dest;

  // memory
  logic [31:0] dmem_q [DMEM_WORDS];
  logic [31:0] mem_rdata;

  // MEM/WB
  logic        memwb_we, memwb_load;
  logic [31:0] memwb_res, memwb_ldata, wb_data;
  logic [4:0]  memwb_dest;

  // ---------------- fetch
  always_ff @(posedge clk_i) begin
    if (imem_we_i) imem_q[imem_addr_i] <= imem_wdata_i;
  end

  assign if_pc4   = pc_q + 32'd4;
  assign if_instr = imem_q[pc_q[IAW+1:2]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pc_q <= '0;
    else if (br_taken) pc_q <= idex_br_target;
    else if (stall)    pc_q <= pc_q;
    else if (jump_go)  pc_q <= id_jmp_target;
    else               pc_q <= if_pc4;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ifid_valid <= 1'b0;
      ifid_instr <= '0;
      ifid_pc4   <= '0;
    end else if (br_taken || jump_go) begin
      ifid_valid <= 1'b0;
      ifid_instr <= '0;
    end else if (!stall) begin
      ifid_valid <= 1'b1;
      ifid_instr <= if_instr;
      ifid_pc4   <= if_pc4;
    end
  end

  // ---------------- decode
  assign id_rs = ifid_instr[25:21];
  assign id_rt = ifid_instr[20:16];
  assign id_rd = ifid_instr[15:11];

  mini_pipe_decoder i_decoder (
    .op_i    (ifid_instr[31:26]),
    .funct_i (ifid_instr[5:0]),
    .ctrl_o  (id_ctrl_raw)
  );

  assign id_ctrl = ifid_valid ? id_ctrl_raw : '0;

  assign id_imm = id_ctrl.ext_sign ? {{16{ifid_instr[15]}}, ifid_instr[15:0]}
                                   : {16'h0, ifid_instr[15:0]};
  assign id_br_target  = ifid_pc4 + {{14{ifid_instr[15]}}, ifid_instr[15:0], 2'b00};
  assign id_jmp_target = {ifid_pc4[31:28], ifid_instr[25:0], 2'b00};
  assign jump_go       = id_ctrl.jump & ~stall;

  mini_pipe_regfile #(.NREG(32), .XLEN(32)) i_regfile (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (memwb_we),
    .waddr_i  (memwb_dest),
    .wdata_i  (wb_data),
    .ra_a_i   (id_rs),
    .rd_a_o   (id_a),
    .ra_b_i   (id_rt),
    .rd_b_o   (id_b),
    .ra_dbg_i (dbg_raddr_i),
    .rd_dbg_o (dbg_rdata_o)
  );

  mini_pipe_hazard i_hazard (
    .ifid_valid_i (ifid_valid),
    .id_rs_i      (id_rs),
    .id_rt_i      (id_rt),
    .id_use_rs_i  (id_ctrl.use_rs),
    .id_use_rt_i  (id_ctrl.use_rt),
    .idex_load_i  (idex_ctrl.mem_to_reg),
    .idex_dest_i  (idex_dest),
    .idex_rs_i    (idex_rs),
    .idex_rt_i    (idex_rt),
    .exmem_we_i   (exmem_we),
    .exmem_dest_i (exmem_dest),
    .memwb_we_i   (memwb_we),
    .memwb_dest_i (memwb_dest),
    .stall_o      (stall),
    .fwd_a_o      (fwd_a),
    .fwd_b_o      (fwd_b)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idex_ctrl      <= '0;
      idex_rs        <= '0;
      idex_rt        <= '0;
      idex_dest      <= '0;
      idex_a         <= '0;
      idex_b         <= '0;
      idex_imm       <= '0;
      idex_br_target <= '0;
    end else if (br_taken || stall) begin
      idex_ctrl      <= '0;
      idex_dest      <= '0;
    end else begin
      idex_ctrl      <= id_ctrl;
      idex_rs        <= id_rs;
      idex_rt        <= id_rt;
      idex_dest      <= id_ctrl.reg_dst ? id_rd : id_rt;
      idex_a         <= id_a;
      idex_b         <= id_b;
      idex_imm       <= id_imm;
      idex_br_target <= id_br_target;
    end
  end

  // ---------------- execute
  always_comb begin
    unique case (fwd_a)
      2'd1:    ex_a = exmem_res;
      2'd2:    ex_a = wb_data;
      default: ex_a = idex_a;
    endcase
    unique case (fwd_b)
      2'd1:    ex_b_reg = exmem_res;
      2'd2:    ex_b_reg = wb_data;
      default: ex_b_reg = idex_b;
    endcase
    ex_b = idex_ctrl.alu_src ? idex_imm : ex_b_reg;
    unique case (idex_ctrl.alu_op)
      ALU_SUB: ex_res = ex_a - ex_b;
      ALU_OR:  ex_res = ex_a | ex_b;
      default: ex_res = ex_a + ex_b;
    endcase
  end

  assign br_taken = idex_ctrl.branch & (ex_res == 32'd0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exmem_we    <= 1'b0;
      exmem_load  <= 1'b0;
      exmem_store <= 1'b0;
      exmem_res   <= '0;
      exmem_sdata <= '0;
      exmem_dest  <= '0;
    end else begin
      exmem_we    <= idex_ctrl.reg_write;
      exmem_load  <= idex_ctrl.mem_to_reg;
      exmem_store <= idex_ctrl.mem_write;
      exmem_res   <= ex_res;
      exmem_sdata <= ex_b_reg;
      exmem_dest  <= idex_dest;
    end
  end

  // ---------------- memory
  always_ff @(posedge clk_i) begin
    if (exmem_store) dmem_q[exmem_res[DAW+1:2]] <= exmem_sdata;
  end

  assign mem_rdata = dmem_q[exmem_res[DAW+1:2]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      memwb_we    <= 1'b0;
      memwb_load  <= 1'b0;
      memwb_res   <= '0;
      memwb_ldata <= '0;
      memwb_dest  <= '0;
    end else begin
      memwb_we    <= exmem_we;
      memwb_load  <= exmem_load;
      memwb_res   <= exmem_res;
      memwb_ldata <= mem_rdata;
      memwb_dest  <= exmem_dest;
    end
  end

  // ---------------- write-back
  assign wb_data = memwb_load ? memwb_ldata : memwb_res;
endmodule

// File: rtl/mini_pipe_core_chk.sv
module mini_pipe_core_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] pc_i,
  input logic        stall_i,
  input logic        br_taken_i,
  input logic [31:0] br_target_i,
  input logic        jump_go_i,
  input logic        ifid_valid_i,
  input logic        idex_busy_i,
  input logic [4:0]  dbg_raddr_i,
  input logic [31:0] dbg_rdata_i
);
  always @(posedge clk_i) begin
    if (!rst_ni) AST_PC_HELD_IN_RESET: assert (pc_i == 32'd0); // R1
  end

  AST_STALL_HOLDS_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i && !br_taken_i |=> $stable(pc_i)); // R6

  AST_STALL_INSERTS_BUBBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> !idex_busy_i); // R6

  AST_BRANCH_FLUSHES_TWO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_taken_i |=> !ifid_valid_i && !idex_busy_i); // R7

  AST_BRANCH_REDIRECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_taken_i |=> pc_i == $past(br_target_i)); // R7

  AST_JUMP_FLUSHES_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jump_go_i && !br_taken_i |=> !ifid_valid_i); // R8

  AST_ZERO_REG_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_raddr_i == 5'd0 |-> dbg_rdata_i == 32'd0); // R9
endmodule

bind mini_pipe_core mini_pipe_core_chk i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .pc_i         (pc_q),
  .stall_i      (stall),
  .br_taken_i   (br_taken),
  .br_target_i  (idex_br_target),
  .jump_go_i    (jump_go),
  .ifid_valid_i (ifid_valid),
  .idex_busy_i  (idex_ctrl.reg_write | idex_ctrl.mem_write | idex_ctrl.branch),
  .dbg_raddr_i  (dbg_raddr_i),
  .dbg_rdata_i  (dbg_rdata_o)
);

// File: tb/test_mini_pipe_core.sv
module test_mini_pipe_core;
  localparam int CLK_PERIOD = 10;
  localparam int IMEM_WORDS = 64;
  localparam int IAW        = $clog2(IMEM_WORDS);

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           imem_we_i = 1'b0;
  logic [IAW-1:0] imem_addr_i = '0;
  logic [31:0]    imem_wdata_i = '0;
  logic [4:0]     dbg_raddr_i;
  logic [31:0]    dbg_rdata_o;

  logic [4:0] main_addr = '0;
  logic [4:0] mon_addr  = '0;
  logic       mon_en    = 1'b0;
  assign dbg_raddr_i = mon_en ? mon_addr : main_addr;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [4:0]  idx;
    logic [31:0] val;
    string       req;
  } sb_item_t;
  sb_item_t sb_q[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  mini_pipe_core #(.IMEM_WORDS(IMEM_WORDS), .DMEM_WORDS(64)) i_mini_pipe_core (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .imem_we_i    (imem_we_i),
    .imem_addr_i  (imem_addr_i),
    .imem_wdata_i (imem_wdata_i),
    .dbg_raddr_i  (dbg_raddr_i),
    .dbg_rdata_o  (dbg_rdata_o)
  );

  function automatic logic [31:0] enc_r(input logic [4:0] rs, rt, rd, input logic [5:0] fn);
    return {6'b000000, rs, rt, rd, 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs, rt,
                                        input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction
  function automatic logic [31:0] enc_j(input logic [25:0] tgt);
    return {6'b000010, tgt};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic expect_reg(input logic [4:0] idx, input logic [31:0] val, input string req);
    sb_item_t it;
    it.idx = idx; it.val = val; it.req = req;
    sb_q.push_back(it);
  endtask

  task automatic load_word(input int addr, input logic [31:0] w);
    @(negedge clk_i);
    imem_we_i    = 1'b1;
    imem_addr_i  = IAW'(addr);
    imem_wdata_i = w;
    @(negedge clk_i);
    imem_we_i    = 1'b0;
  endtask

  // monitor: pops expectations and compares through the debug read port
  initial begin
    forever begin
      @(negedge clk_i);
      if (sb_q.size() != 0) begin
        sb_item_t it;
        it = sb_q.pop_front();
        mon_addr = it.idx;
        mon_en   = 1'b1;
        #1;
        check(dbg_rdata_o === it.val, $sformatf("%s r%0d", it.req, it.idx), dbg_rdata_o, it.val);
        mon_en   = 1'b0;
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=%08h expected=%08h", 32'd0, 32'd1);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  logic [31:0] prog [25];

  initial begin
    prog[0]  = enc_i(6'b001101, 5'd0, 5'd1, 16'h0005);   // ori r1=5
    prog[1]  = enc_i(6'b001101, 5'd0, 5'd2, 16'h0003);   // ori r2=3
    prog[2]  = enc_r(5'd1, 5'd2, 5'd3, 6'b100000);       // add r3 (forwarded)
    prog[3]  = enc_r(5'd1, 5'd2, 5'd4, 6'b100010);       // sub r4
    prog[4]  = enc_i(6'b001101, 5'd0, 5'd5, 16'hF000);   // ori zero-extend
    prog[5]  = enc_i(6'b101011, 5'd0, 5'd3, 16'h0008);   // sw r3 -> word 2
    prog[6]  = enc_i(6'b001101, 5'd0, 5'd6, 16'h0010);   // ori r6=16
    prog[7]  = enc_i(6'b101011, 5'd6, 5'd4, 16'hFFFC);   // sw r4 -> 16-4
    prog[8]  = enc_i(6'b100011, 5'd0, 5'd7, 16'h0008);   // lw r7
    prog[9]  = enc_r(5'd7, 5'd7, 5'd8, 6'b100000);       // load-use
    prog[10] = enc_i(6'b100011, 5'd0, 5'd9, 16'h000C);   // lw r9
    prog[11] = enc_i(6'b001101, 5'd0, 5'd0, 16'h1234);   // write to r0
    prog[12] = enc_r(5'd0, 5'd1, 5'd10, 6'b100000);      // r10 = r0 + r1
    prog[13] = enc_i(6'b000100, 5'd1, 5'd2, 16'h0005);   // beq not taken
    prog[14] = enc_i(6'b001101, 5'd0, 5'd11, 16'h0001);
    prog[15] = enc_i(6'b000100, 5'd1, 5'd1, 16'h0002);   // beq taken -> 18
    prog[16] = enc_i(6'b001101, 5'd0, 5'd12, 16'h0BAD);  // flushed
    prog[17] = enc_i(6'b001101, 5'd0, 5'd13, 16'h0BAD);  // flushed
    prog[18] = enc_j(26'd21);                            // j -> 21
    prog[19] = enc_i(6'b001101, 5'd0, 5'd14, 16'h0BAD);  // flushed
    prog[20] = enc_i(6'b001101, 5'd0, 5'd15, 16'h0BAD);  // skipped
    prog[21] = 32'hFFFF_FFFF;                            // unsupported
    prog[22] = enc_i(6'b001101, 5'd0, 5'd16, 16'h0077);
    prog[23] = enc_r(5'd2, 5'd1, 5'd17, 6'b100010);      // 3-5
    prog[24] = enc_j(26'd24);                            // park

    rst_ni = 1'b0;
    for (int a = 0; a < IMEM_WORDS; a++) load_word(a, (a < 25) ? prog[a] : 32'd0);

    // R1: register state during reset
    @(negedge clk_i);
    main_addr = 5'd1; #1;
    check(dbg_rdata_o === 32'd0, "R1 reset r1", dbg_rdata_o, 32'd0);
    main_addr = 5'd31; #1;
    check(dbg_rdata_o === 32'd0, "R1 reset r31", dbg_rdata_o, 32'd0);

    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (80) @(negedge clk_i);

    expect_reg(5'd1,  32'd5,        "R2");
    expect_reg(5'd2,  32'd3,        "R2");
    expect_reg(5'd3,  32'd8,        "R4");
    expect_reg(5'd4,  32'd2,        "R2");
    expect_reg(5'd5,  32'h0000F000, "R2");
    expect_reg(5'd6,  32'd16,       "R4");
    expect_reg(5'd7,  32'd8,        "R5");
    expect_reg(5'd8,  32'd16,       "R6");
    expect_reg(5'd9,  32'd2,        "R3");
    expect_reg(5'd0,  32'd0,        "R9");
    expect_reg(5'd10, 32'd5,        "R9");
    expect_reg(5'd11, 32'd1,        "R7");
    expect_reg(5'd12, 32'd0,        "R7");
    expect_reg(5'd13, 32'd0,        "R7");
    expect_reg(5'd14, 32'd0,        "R8");
    expect_reg(5'd15, 32'd0,        "R8");
    expect_reg(5'd16, 32'h00000077, "R8");
    expect_reg(5'd17, 32'hFFFFFFFE, "R2");
    expect_reg(5'd31, 32'd0,        "R10");
    wait (sb_q.size() == 0);
    repeat (3) @(negedge clk_i);

    // R1: reset again clears architectural state
    rst_ni = 1'b0;
    main_addr = 5'd3; #1;
    check(dbg_rdata_o === 32'd0, "R1 re-reset r3", dbg_rdata_o, 32'd0);
    @(negedge clk_i);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule